// File: doc/BRIEF.md
# DDR SDRAM Rank Power-Up Sequencer

This block brings each populated rank of a DDR SDRAM from power-up to normal operation. After reset it waits a startup interval that covers the settling time needed after a DRAM clock change. It then walks every rank through a fixed list of commands. For each command it presents a 3-bit command code and an address, and raises a strobe for one cycle. When the last rank has entered normal mode it raises a done flag.

A mode-register value reaches the DRAM on the address bus. The value sits three bits up, because the lowest three address bits select a byte within a 64-bit word. The final mode load is built from the chosen CAS latency and a burst-length-8 flag.

Each rank has its own base address. Rank 0 starts at zero. Every later rank starts at the cumulative end-address value of the rank before it, taken in 32 MB units. All waits are cycle counters derived from the clock frequency parameter, so a bench can shrink them.

Top module: `ddr_rank_init`

## Requirements
- R1: Command codes are NORMAL=000, NOP=001, PRECHARGE-ALL=010, MODE-LOAD=011 and AUTO-REFRESH=100. Each issued command is marked by `cmd_stb` high for exactly one cycle.
- R2: While reset is held and just after it, `cmd_stb`=0, `done`=0, `cmd`=NOP and `addr`=0. The first strobe comes exactly INIT_CYC = STARTUP_US*CLK_MHZ cycles after reset is released.
- R3: Each rank receives 7+REF_COUNT commands in this order: NOP, PRECHARGE-ALL, MODE-LOAD, MODE-LOAD, PRECHARGE-ALL, REF_COUNT (default 8) AUTO-REFRESH, MODE-LOAD, NORMAL.
- R4: The first mode load carries base+0x2000 and the second carries base+0x800. Every command other than the three mode loads carries the rank base. Every strobed address has bits 2:0 equal to zero.
- R5: The final mode load carries base + {cas,1,bl,000}. The CAS field (address bits 9:7) is 010 for `cas_code`=01 (CAS 2), 110 for 10 (CAS 2.5), and 011 for 00 or 11 (CAS 3). The burst field (bits 5:3) is 011 when `bl8`=1 and 010 otherwise. Bit 6 is 1 (interleaved). This gives 0x150, 0x350 or 0x1D0, plus 0x8 when `bl8` is set.
- R6: The gap from one strobe to the next is MRS_US*CLK_MHZ cycles after each of the first two mode loads and REF_US*CLK_MHZ cycles after each auto-refresh. Everywhere else it is GAP_CYC, including from a NORMAL to the next rank's NOP.
- R7: `rank_top`+1 ranks are sequenced in order. Rank 0 uses base 0, and rank k uses base `rank_end[k-1]` * 2^25, where `rank_end[k]` is bits k*END_W +: END_W.
- R8: `done` rises in the cycle after the last rank's NORMAL strobe. It stays high until reset, and no strobe occurs while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; restarts the whole sequence |
| rank_top | input | RW | Index of the last populated rank (rank count minus one) |
| cas_code | input | 2 | CAS selection: 01 = 2, 10 = 2.5, other = 3 |
| bl8 | input | 1 | Selects burst length 8 instead of 4 |
| rank_end | input | RANKS*END_W | Cumulative end address per rank, in 32 MB units |
| cmd | output | 3 | Command code |
| addr | output | ADDR_W | Command address |
| cmd_stb | output | 1 | One-cycle marker of a new command |
| done | output | 1 | All ranks are in normal mode |

## Verification
The hardest state to reach from the ports is the last rank's base address. It only appears after every earlier rank has finished its long refresh waits, and only when `rank_top` is at its maximum. The bench scales the clock parameter down so that the microsecond waits become a few hundred cycles. It then runs full four-rank sequences with random cumulative end values and random CAS and burst settings. Every strobe's code, address and arrival cycle is compared with an independently computed schedule.

// File: rtl/ddr_rank_init.sv
module ddr_rank_init #(
  parameter int CLK_MHZ    = 200,
  parameter int STARTUP_US = 200,
  parameter int MRS_US     = 1,
  parameter int REF_US     = 100,
  parameter int GAP_CYC    = 2,
  parameter int REF_COUNT  = 8,
  parameter int RANKS      = 4,
  parameter int END_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int BASE_SHIFT = 25,
  localparam int RW        = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [RW-1:0]          rank_top,
  input  logic [1:0]             cas_code,
  input  logic                   bl8,
  input  logic [RANKS*END_W-1:0] rank_end,
  output logic [2:0]             cmd,
  output logic [ADDR_W-1:0]      addr,
  output logic                   cmd_stb,
  output logic                   done
);
  localparam int INIT_CYC = STARTUP_US * CLK_MHZ;
  localparam int MRS_CYC  = MRS_US * CLK_MHZ;
  localparam int REF_CYC  = REF_US * CLK_MHZ;
  localparam int LAST     = REF_COUNT + 6;
  localparam int SW       = $clog2(LAST + 1);
  localparam int CW       = $clog2(INIT_CYC + REF_CYC + MRS_CYC + GAP_CYC + 1);

  localparam logic [2:0] C_NORMAL = 3'd0;
  localparam logic [2:0] C_NOP    = 3'd1;
  localparam logic [2:0] C_PRE    = 3'd2;
  localparam logic [2:0] C_MRS    = 3'd3;
  localparam logic [2:0] C_CBR    = 3'd4;

  logic [SW-1:0]     step;
  logic [RW-1:0]     rank;
  logic [CW-1:0]     wcnt;
  logic              fin;
  logic [ADDR_W-1:0] base;
  logic [2:0]        s_cmd;
  logic [ADDR_W-1:0] s_off;
  logic [CW-1:0]     s_wait;
  logic [END_W-1:0]  end_sel;

  wire [2:0] cas_f = (cas_code == 2'b01) ? 3'b010 :
                     (cas_code == 2'b10) ? 3'b110 : 3'b011;
  wire [2:0] bl_f  = bl8 ? 3'b011 : 3'b010;
  wire [9:0] mode  = {cas_f, 1'b1, bl_f, 3'b000};

  assign end_sel = rank_end[rank*END_W +: END_W];

  always_comb begin
    s_cmd  = C_NORMAL;
    s_off  = '0;
    s_wait = CW'(GAP_CYC);
    if (step == SW'(0)) begin
      s_cmd = C_NOP;
    end else if (step == SW'(1) || step == SW'(4)) begin
      s_cmd = C_PRE;
    end else if (step == SW'(2)) begin
      s_cmd  = C_MRS;
      s_off  = ADDR_W'(32'h2000);
      s_wait = CW'(MRS_CYC);
    end else if (step == SW'(3)) begin
      s_cmd  = C_MRS;
      s_off  = ADDR_W'(32'h800);
      s_wait = CW'(MRS_CYC);
    end else if (step <= SW'(4 + REF_COUNT)) begin
      s_cmd  = C_CBR;
      s_wait = CW'(REF_CYC);
    end else if (step == SW'(5 + REF_COUNT)) begin
      s_cmd = C_MRS;
      s_off = ADDR_W'(mode);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= '0;
      rank    <= '0;
      wcnt    <= CW'(INIT_CYC - 1);
      fin     <= 1'b0;
      base    <= '0;
      cmd     <= C_NOP;
      addr    <= '0;
      cmd_stb <= 1'b0;
      done    <= 1'b0;
    end else begin
      cmd_stb <= 1'b0;
      done    <= fin;
      if (!fin) begin
        if (wcnt != '0) begin
          wcnt <= wcnt - 1'b1;
        end else begin
          cmd_stb <= 1'b1;
          cmd     <= s_cmd;
          addr    <= base + s_off;
          wcnt    <= s_wait - 1'b1;
          if (step == SW'(LAST)) begin
            step <= '0;
            if (rank == rank_top) begin
              fin <= 1'b1;
            end else begin
              rank <= rank + 1'b1;
              base <= ADDR_W'(end_sel) << BASE_SHIFT;
            end
          end else begin
            step <= step + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ddr_rank_init_chk.sv
module ddr_rank_init_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              cmd_stb,
  input logic              done
);
  p_cmd_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> (cmd <= 3'd4));

  p_lane_bits_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> (addr[2:0] == 3'b000));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_quiet_when_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_stb);

  p_done_after_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(cmd_stb) && cmd == 3'd0));
endmodule

bind ddr_rank_init ddr_rank_init_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .cmd_stb(cmd_stb), .done(done)
);

// File: tb/tb_ddr_rank_init.sv
module tb_ddr_rank_init;
  localparam int MHZ = 2, NR = 4, EW = 8, AW = 32;
  localparam int INIT_C = 200 * MHZ, MRS_C = 1 * MHZ, REF_C = 100 * MHZ, GAP_C = 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] rank_top = 0, cas_code = 0;
  logic bl8 = 0;
  logic [NR*EW-1:0] rank_end = 0;
  logic [2:0] cmd;
  logic [AW-1:0] addr;
  logic cmd_stb, done;
  int cyc, errors = 0, checks = 0;
  bit finished = 0;

  ddr_rank_init #(.CLK_MHZ(MHZ), .RANKS(NR), .END_W(EW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .rank_top(rank_top), .cas_code(cas_code), .bl8(bl8),
    .rank_end(rank_end), .cmd(cmd), .addr(addr), .cmd_stb(cmd_stb), .done(done));

  always #10 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] e_cmd(int s);
    if (s == 0) return 3'd1;
    if (s == 1 || s == 4) return 3'd2;
    if (s == 2 || s == 3 || s == 13) return 3'd3;
    if (s >= 5 && s <= 12) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [AW-1:0] e_addr(int s, logic [AW-1:0] b, logic [1:0] c, bit l8);
    logic [AW-1:0] m;
    if (s == 2) return b + 32'h2000;
    if (s == 3) return b + 32'h800;
    if (s == 13) begin
      m = (c == 2'b01) ? 32'h150 : (c == 2'b10) ? 32'h350 : 32'h1D0;
      return b + m + (l8 ? 32'h8 : 32'h0);
    end
    return b;
  endfunction

  function automatic int e_gap(int prev);
    if (prev == 2 || prev == 3) return MRS_C;
    if (prev >= 5 && prev <= 12) return REF_C;
    return GAP_C;
  endfunction

  task automatic run_case(input logic [1:0] rt, input logic [1:0] cs, input bit l8,
                          input logic [NR*EW-1:0] ends);
    int last_at, at, n;
    logic [AW-1:0] b;
    bit lost;
    rank_top = rt; cas_code = cs; bl8 = l8; rank_end = ends;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!cmd_stb && !done && cmd == 3'd1 && addr == 0, "R2", "reset state",
        {cmd_stb, done, cmd}, 3'd1);
    rst_n = 1;
    last_at = 0; lost = 0;
    for (int r = 0; r <= rt && !lost; r++) begin
      b = (r == 0) ? '0 : (AW'(ends[(r-1)*EW +: EW]) << 25);
      for (int s = 0; s < 15 && !lost; s++) begin
        n = 0;
        do begin @(negedge clk); n++; end while (!cmd_stb && n < 1000);
        if (!cmd_stb) begin
          chk(0, "R3", "missing strobe", 0, s);
          lost = 1;
        end else begin
          at = cyc;
          if (r == 0 && s == 0) chk(at == INIT_C, "R2", "first strobe cycle", at, INIT_C);
          else chk(at - last_at == e_gap((s == 0) ? 14 : s - 1), "R6", "strobe spacing",
                   at - last_at, e_gap((s == 0) ? 14 : s - 1));
          chk(cmd == e_cmd(s), "R3", "command order", cmd, e_cmd(s));
          chk(addr == e_addr(s, b, cs, l8), (s == 13) ? "R5" : ((r > 0) ? "R7" : "R4"),
              "address", addr, e_addr(s, b, cs, l8));
          last_at = at;
          @(negedge clk);
          if (r == rt && s == 14) begin
            chk(done && !cmd_stb, "R8", "done after final normal", done, 1);
          end else begin
            chk(!cmd_stb, "R1", "one-cycle strobe", cmd_stb, 0);
          end
        end
      end
    end
    if (!lost) begin
      bit stray = 0;
      repeat (60) begin @(negedge clk); if (cmd_stb || !done) stray = 1; end
      chk(!stray, "R8", "done held with no strobes", stray, 0);
    end
  endtask

  initial begin
    logic [NR*EW-1:0] ends;
    int e;
    void'($urandom(32'd1234));
    run_case(2'd0, 2'b01, 1'b0, {8'd0, 8'd0, 8'd0, 8'd4});
    run_case(2'd3, 2'b11, 1'b1, {8'd120, 8'd64, 8'd32, 8'd16});
    run_case(2'd1, 2'b10, 1'b1, {8'd0, 8'd0, 8'd9, 8'd3});
    run_case(2'd1, 2'b00, 1'b0, {8'd0, 8'd0, 8'd2, 8'd1});
    for (int k = 0; k < 4; k++) begin
      e = 0;
      for (int r = 0; r < NR; r++) begin
        e = e + 1 + int'($urandom % 8);
        ends[r*EW +: EW] = EW'(e);
      end
      run_case(2'($urandom % 4), 2'($urandom % 4), 1'($urandom % 2), ends);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule